// File: doc/BRIEF.md
# I2C Controller Interrupt Collector

This block gathers the twelve interrupt causes of an I2C controller into one raw status vector. It applies a programmable enable mask to produce a masked status and a single interrupt line. Ten of the causes are event pulses that are latched until software clears them. Each latched cause has its own clear address, and a read of that address clears it. A separate clear-all address clears every latched cause at once. The two FIFO threshold causes are not latched. They follow the live FIFO fill levels, compared against two programmable thresholds.

When an abort is reported, the block also keeps a sticky record of the reasons for it. The abort-clear read, or the clear-all read, wipes that record. Software reaches the block through a plain register bus: a word address, a write strobe, a read strobe and a registered read-data port. The controller's bus engine lives elsewhere and only supplies the event pulses, the abort reasons and the FIFO levels.

Top module: `irq_collect`

## Requirements
- R1: The raw status vector uses these bit positions: 0 receive underflow, 1 receive overflow, 2 receive threshold, 3 transmit overflow, 4 transmit threshold, 5 read request, 6 abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Bits 2 and 4 are level causes and all others are latched.
- R2: A one-cycle pulse on a latched cause's event input sets its raw bit at the next clock edge. The bit stays set until it is cleared.
- R3: A read of clear address 0x10+k returns the prior value of raw bit k in read-data bit 0, with all other bits zero. The same read clears latched bit k and leaves every other bit unchanged.
- R4: A read of the clear-all address 0x06 returns the raw status as it was before the read. It clears every latched bit and the abort reason record.
- R5: An event pulse that arrives in the same cycle as a clear read of that cause leaves the bit set.
- R6: The mask register (0x02, 12 bits) resets to zero. The masked status at 0x01 reads as raw status AND mask.
- R7: irq_o is the OR of all masked status bits, registered. It follows a change of raw status or mask one clock edge later.
- R8: Bit 2 is 1 while rx_level_i is greater than the receive threshold (0x03). Bit 4 is 1 while tx_level_i is less than or equal to the transmit threshold (0x04). Reads of their clear addresses (0x12, 0x14) do not change them.
- R9: The abort reason record (0x05) ORs in abrt_cause_i on each abort event pulse (bit 6). It is zeroed by a read of 0x16 or 0x06. An abort event in the same cycle as that read leaves only the new reasons.
- R10: After reset, all latched bits, the mask, both thresholds, the abort record and irq_o are zero.
- R11: Read data is registered and appears on the clock edge that takes the read. Unmapped addresses read as zero. Writes to read-only addresses (0x00, 0x01, 0x05) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 12 | Per-cause event pulses; bits 2 and 4 are ignored |
| abrt_cause_i | input | 13 | Abort reasons, sampled when evt_i[6] is high |
| rx_level_i | input | 5 | Receive FIFO fill level |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| bus_addr_i | input | 5 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (clear registers act on it) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt line |

## Verification
- Latency of each result:
  - An event pulse is visible in raw status one edge after it is driven.
  - irq_o follows one edge after that.
  - A threshold or level change reaches bits 2 and 4 one edge after the threshold register loads.
  - Read data appears on the same edge that performs a clear.
- How the bench keeps to these latencies:
  - It drives stimulus at falling edges and samples read data at the falling edge after the read's rising edge.
  - After writes or level changes, it waits at least two edges before reading status.
  - For the interrupt line, it samples both the edge where it must still be low and the one where it must rise.

// File: rtl/irq_collect_pkg.sv
package irq_collect_pkg;
  localparam int NSRC       = 12;
  localparam int SRC_RXFULL = 2;
  localparam int SRC_TXEMPT = 4;
  localparam int SRC_ABORT  = 6;
  localparam logic [NSRC-1:0] LATCH_MASK = 12'hFEB;

  localparam int A_RAW    = 0;
  localparam int A_MSTAT  = 1;
  localparam int A_MASK   = 2;
  localparam int A_RXTHR  = 3;
  localparam int A_TXTHR  = 4;
  localparam int A_CAUSE  = 5;
  localparam int A_CLRALL = 6;
  localparam int A_CLR0   = 16;
endpackage

// File: rtl/irq_latch_bit.sv
module irq_latch_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC = 12,
  parameter int LVL_W = 5,
  parameter logic [NSRC-1:0] LATCH = 12'hFEB,
  parameter int RXF = 2,
  parameter int TXE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  evt_i,
  input  logic [NSRC-1:0]  clr_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  output logic [NSRC-1:0]  raw_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (LATCH[k]) begin : g_latch
      irq_latch_bit u_bit (
        .clk(clk), .rst(rst), .set_i(evt_i[k]), .clr_i(clr_i[k]), .q_o(raw_o[k])
      );
    end else if (k == RXF) begin : g_rxfull
      always_ff @(posedge clk) begin
        if (rst) raw_o[k] <= 1'b0;
        else     raw_o[k] <= (rx_level_i > rx_thr_i);
      end
    end else if (k == TXE) begin : g_txempty
      always_ff @(posedge clk) begin
        if (rst) raw_o[k] <= 1'b0;
        else     raw_o[k] <= (tx_level_i <= tx_thr_i);
      end
    end else begin : g_none
      assign raw_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NSRC = 12,
  parameter int LVL_W = 5,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int A_MASK = 2,
  parameter int A_RXTHR = 3,
  parameter int A_TXTHR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [LVL_W-1:0]  rx_thr_o,
  output logic [LVL_W-1:0]  tx_thr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o   <= '0;
      rx_thr_o <= '0;
      tx_thr_o <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(A_MASK))  mask_o   <= wdata_i[NSRC-1:0];
      if (addr_i == ADDR_W'(A_RXTHR)) rx_thr_o <= wdata_i[LVL_W-1:0];
      if (addr_i == ADDR_W'(A_TXTHR)) tx_thr_o <= wdata_i[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/irq_abort_cause.sv
module irq_abort_cause #(
  parameter int ABRT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ABRT_W-1:0] cause_i,
  output logic [ABRT_W-1:0] cause_o
);
  always_ff @(posedge clk) begin
    if (rst) cause_o <= '0;
    else     cause_o <= (clr_i ? '0 : cause_o) | (set_i ? cause_i : '0);
  end
endmodule

// File: rtl/irq_collect.sv
module irq_collect
  import irq_collect_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int ABRT_W = 13,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       evt_i,
  input  logic [ABRT_W-1:0] abrt_cause_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0]   raw_stat;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   clr_vec;
  logic [LVL_W-1:0]  rx_thr, tx_thr;
  logic [ABRT_W-1:0] abrt_cause;
  logic [DATA_W-1:0] rd_mux;
  logic              clr_all;

  assign clr_all = bus_rd_i && (bus_addr_i == ADDR_W'(A_CLRALL));

  for (genvar k = 0; k < NSRC; k++) begin : g_clr
    assign clr_vec[k] = clr_all || (bus_rd_i && (bus_addr_i == ADDR_W'(A_CLR0 + k)));
  end

  irq_cfg_regs #(
    .NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_MASK(A_MASK), .A_RXTHR(A_RXTHR), .A_TXTHR(A_TXTHR)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .mask_o(mask_q), .rx_thr_o(rx_thr), .tx_thr_o(tx_thr)
  );

  irq_src_bank #(
    .NSRC(NSRC), .LVL_W(LVL_W), .LATCH(LATCH_MASK),
    .RXF(SRC_RXFULL), .TXE(SRC_TXEMPT)
  ) u_bank (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(clr_vec),
    .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
    .rx_thr_i(rx_thr), .tx_thr_i(tx_thr), .raw_o(raw_stat)
  );

  irq_abort_cause #(.ABRT_W(ABRT_W)) u_cause (
    .clk(clk), .rst(rst), .set_i(evt_i[SRC_ABORT]), .clr_i(clr_vec[SRC_ABORT]),
    .cause_i(abrt_cause_i), .cause_o(abrt_cause)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      ADDR_W'(A_RAW):    rd_mux = DATA_W'(raw_stat);
      ADDR_W'(A_MSTAT):  rd_mux = DATA_W'(raw_stat & mask_q);
      ADDR_W'(A_MASK):   rd_mux = DATA_W'(mask_q);
      ADDR_W'(A_RXTHR):  rd_mux = DATA_W'(rx_thr);
      ADDR_W'(A_TXTHR):  rd_mux = DATA_W'(tx_thr);
      ADDR_W'(A_CAUSE):  rd_mux = DATA_W'(abrt_cause);
      ADDR_W'(A_CLRALL): rd_mux = DATA_W'(raw_stat);
      default: begin
        for (int k = 0; k < NSRC; k++)
          if (bus_addr_i == ADDR_W'(A_CLR0 + k)) rd_mux = DATA_W'(raw_stat[k]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      if (bus_rd_i) bus_rdata_o <= rd_mux;
      irq_o <= |(raw_stat & mask_q);
    end
  end
endmodule

// File: rtl/irq_collect_chk.sv
module irq_collect_chk #(
  parameter int ABRT_W = 13,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [11:0]       evt_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [11:0]       raw_stat,
  input logic [ABRT_W-1:0] abrt_cause
);
  // R2
  stop_latch_chk: assert property (@(posedge clk) disable iff (rst)
    evt_i[9] |=> raw_stat[9]);
  // R3
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == ADDR_W'(25) && !evt_i[9]) |=> !raw_stat[9]);
  // R5
  clear_race_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == ADDR_W'(22) && evt_i[6]) |=> raw_stat[6]);
  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == ADDR_W'(6) && evt_i == '0) |=> ((raw_stat & 12'hFEB) == '0));
  // R9
  cause_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == ADDR_W'(22) && !evt_i[6]) |=> (abrt_cause == '0));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == ADDR_W'(10)) |=> (bus_rdata_o == '0));
endmodule

bind irq_collect irq_collect_chk #(.ABRT_W(ABRT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .raw_stat(raw_stat), .abrt_cause(abrt_cause)
);

// File: tb/irq_collect_test.sv
module irq_collect_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [11:0] evt_i = '0;
  logic [12:0] abrt_cause_i = '0;
  logic [4:0]  rx_level_i = '0, tx_level_i = '0;
  logic [4:0]  bus_addr_i = '0;
  logic        bus_wr_i = 0, bus_rd_i = 0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_o;
  int nvec = 0, nbad = 0;
  logic [15:0] rv;
  logic [11:0] exp_raw;

  always #10 clk = ~clk;

  irq_collect uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .abrt_cause_i(abrt_cause_i),
    .rx_level_i(rx_level_i), .tx_level_i(tx_level_i), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); bus_addr_i = 5'(a); bus_rd_i = 1;
    @(negedge clk); bus_rd_i = 0; d = bus_rdata_o;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); bus_addr_i = 5'(a); bus_wdata_i = d; bus_wr_i = 1;
    @(negedge clk); bus_wr_i = 0;
  endtask

  task automatic pulse(input logic [11:0] e, input logic [12:0] c);
    @(negedge clk); evt_i = e; abrt_cause_i = c;
    @(negedge clk); evt_i = '0; abrt_cause_i = '0;
  endtask

  task automatic pulse_rd(input logic [11:0] e, input logic [12:0] c, input int a,
                          output logic [15:0] d);
    @(negedge clk); evt_i = e; abrt_cause_i = c; bus_addr_i = 5'(a); bus_rd_i = 1;
    @(negedge clk); evt_i = '0; abrt_cause_i = '0; bus_rd_i = 0; d = bus_rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R10 reset state (tx level 0 <= threshold 0 sets bit 4, R8)
    rd(0, rv);  chk("R10 raw", rv, 16'h0010);
    rd(2, rv);  chk("R10 mask", rv, 16'h0000);
    rd(3, rv);  chk("R10 rxthr", rv, 16'h0000);
    rd(5, rv);  chk("R10 cause", rv, 16'h0000);
    chk("R10 irq", {15'd0, irq_o}, 16'h0000);

    // R1 R2 R3: sweep every latched cause
    for (int k = 0; k < 12; k++) begin
      if (k == 2 || k == 4) continue;
      pulse(12'(1 << k), 13'h0);
      rd(0, rv);      chk("R2 set", rv, 16'h0010 | 16'(1 << k));
      rd(16 + k, rv); chk("R3 clr ret", rv, 16'h0001);
      rd(0, rv);      chk("R3 cleared", rv, 16'h0010);
      rd(16 + k, rv); chk("R3 clr again", rv, 16'h0000);
    end

    // R8 threshold sweep
    for (int t = 0; t < 5; t++) begin
      wr(3, 16'(t)); wr(4, 16'(t));
      for (int l = 0; l < 6; l++) begin
        @(negedge clk); rx_level_i = 5'(l); tx_level_i = 5'(l);
        repeat (2) @(negedge clk);
        rd(0, rv);
        chk("R8 level", rv, {11'd0, (l <= t), 1'b0, (l > t), 2'b00});
      end
    end

    // R8 clear reads of level causes have no effect
    wr(3, 16'd0); wr(4, 16'd3);
    @(negedge clk); rx_level_i = 5'd2; tx_level_i = 5'd1;
    repeat (2) @(negedge clk);
    rd(18, rv); chk("R8 clr rxf ret", rv, 16'h0001);
    rd(20, rv); chk("R8 clr txe ret", rv, 16'h0001);
    rd(0, rv);  chk("R8 level kept", rv, 16'h0014);

    // R6 R7 mask sweep: raw = latched all + bit2, bit4 cleared
    @(negedge clk); tx_level_i = 5'd9;
    pulse(12'hFFF, 13'h0);
    exp_raw = 12'hFEF;
    rd(0, rv); chk("R1 all raw", rv, {4'd0, exp_raw});
    for (int m = 0; m < 4096; m += 273) begin
      wr(2, 16'(m));
      repeat (2) @(negedge clk);
      rd(1, rv); chk("R6 masked", rv, {4'd0, exp_raw & 12'(m)});
      chk("R7 irq", {15'd0, irq_o}, {15'd0, |(exp_raw & 12'(m))});
    end
    wr(2, 16'h0010); repeat (2) @(negedge clk);
    chk("R7 irq masked level off", {15'd0, irq_o}, 16'h0000);

    // R4 clear all
    rd(6, rv); chk("R4 clrall ret", rv, {4'd0, exp_raw});
    rd(0, rv); chk("R4 after", rv, 16'h0004);

    // R7 timing
    wr(2, 16'h0200); repeat (2) @(negedge clk);
    chk("R7 idle", {15'd0, irq_o}, 16'h0000);
    @(negedge clk); evt_i = 12'h200;
    @(negedge clk); evt_i = '0;
    chk("R7 not yet", {15'd0, irq_o}, 16'h0000);
    @(negedge clk);
    chk("R7 rise", {15'd0, irq_o}, 16'h0001);
    rd(25, rv);
    @(negedge clk);
    chk("R7 fall", {15'd0, irq_o}, 16'h0000);

    // R5 same-cycle event and clear
    pulse_rd(12'h200, 13'h0, 25, rv); chk("R5 ret", rv, 16'h0000);
    rd(0, rv); chk("R5 kept", rv, 16'h0204);
    rd(25, rv);

    // R9 abort record
    pulse(12'h040, 13'h0005);
    rd(5, rv); chk("R9 first", rv, 16'h0005);
    pulse(12'h040, 13'h0100);
    rd(5, rv); chk("R9 accum", rv, 16'h0105);
    pulse_rd(12'h040, 13'h0002, 22, rv); chk("R9 clr ret", rv, 16'h0001);
    rd(5, rv); chk("R9 new only", rv, 16'h0002);
    rd(0, rv); chk("R9 raw kept", rv, 16'h0044);
    rd(22, rv);
    rd(5, rv); chk("R9 wiped", rv, 16'h0000);
    pulse(12'h040, 13'h1FFF);
    rd(6, rv);
    rd(5, rv); chk("R9 clrall wipe", rv, 16'h0000);

    // R11 unmapped and read-only
    rd(10, rv); chk("R11 unmapped", rv, 16'h0000);
    rd(31, rv); chk("R11 unmapped hi", rv, 16'h0000);
    wr(0, 16'hFFFF); wr(1, 16'hFFFF); wr(5, 16'hFFFF);
    rd(0, rv); chk("R11 ro raw", rv, 16'h0004);
    rd(5, rv); chk("R11 ro cause", rv, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule